// File: doc/BRIEF.md
# Nibble-Immediate Single-Cycle 8-bit Core

This block is a small 8-bit processor that retires one instruction on every rising clock edge. It holds a program counter, four 8-bit general registers, a 4-bit immediate extender, a four-function ALU with a zero flag, and the instruction decode. It fetches from a separate instruction memory and accesses a separate data memory. Both memories sit outside the core, are read combinationally, and are written on the rising edge.

An instruction is one byte. Bits [7:4] hold the opcode. Register-form instructions carry a destination or base-value selector in bits [3:2] (RD) and a source or address selector in bits [1:0] (RS). Immediate-form instructions carry a 4-bit immediate in bits [3:0]. The two immediate loads always target register 3: one places the nibble low, the other places it high. A program builds a full byte from them with a move and an add. The conditional branch tests REG[RS] for zero. When it is taken, the branch adds REG[RD] + 1 to the PC, with 8-bit wraparound. A taken branch with REG[RD] = 0xFF therefore holds the PC in place.

Top module: `nib_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC (`imem_addr`) and all four registers become 0. `dmem_we` is 0 while `rst` is high.
- R2: Opcode 4'b1100 writes {4'h0, imm} into register 3 and advances the PC by 1.
- R3: Opcode 4'b1101 writes {imm, 4'h0} into register 3 and advances the PC by 1.
- R4: Opcode 4'b1000 writes the data memory byte at address REG[RS] (`dmem_rdata`) into REG[RD].
- R5: `dmem_addr` always shows REG[RS] and `dmem_wdata` always shows REG[RD]. `dmem_we` is 1 only for opcode 4'b1001, which stores REG[RD] at MEM[REG[RS]].
- R6: Opcode 4'b0010 sets REG[RD] to (REG[RD] + REG[RS]) mod 256.
- R7: Opcode 4'b0011 sets REG[RD] to REG[RS].
- R8: Opcode 4'b0111 with REG[RS] = 0 sets the PC to (PC + REG[RD] + 1) mod 256.
- R9: Opcode 4'b0111 with REG[RS] != 0 advances the PC by 1.
- R10: Every other opcode writes neither a register nor memory and advances the PC by 1.
- R11: `imem_addr` is the PC. Every instruction other than a taken branch advances the PC by exactly 1, with 8-bit wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction fetch address (the PC) |
| imem_data | input | 8 | Instruction byte at `imem_addr` |
| dmem_addr | output | 8 | Data address, REG[RS] |
| dmem_wdata | output | 8 | Store data, REG[RD] |
| dmem_rdata | input | 8 | Data byte at `dmem_addr` |
| dmem_we | output | 1 | Data memory write enable |

## Verification
Register contents are never visible at the ports, so every register write has to be proven by a later store that exposes it. The bench program follows each kind of write with a store whose data is compared. Each register carries a record of which instruction last wrote it, so a wrong value is traced back to the requirement that produced it. The hardest case to reach is a taken branch whose offset wraps past 255. With only nibble immediates, the program must first build 0xFF from a high-nibble load, a move, a low-nibble load and an add, and then branch on a zeroed register. The result is a self-loop, and the PC must stay fixed at that address for the rest of the run.

// File: rtl/nib_core.sv
module nib_core (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] imem_addr,
  input  logic [7:0] imem_data,
  output logic [7:0] dmem_addr,
  output logic [7:0] dmem_wdata,
  input  logic [7:0] dmem_rdata,
  output logic       dmem_we
);
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_MOV = 4'b0011;
  localparam logic [3:0] OP_BZ  = 4'b0111;
  localparam logic [3:0] OP_LW  = 4'b1000;
  localparam logic [3:0] OP_SW  = 4'b1001;
  localparam logic [3:0] OP_LI  = 4'b1100;
  localparam logic [3:0] OP_LUI = 4'b1101;

  typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_A = 2'b01, ALU_B = 2'b10, ALU_ZERO = 2'b11} alu_op_t;

  logic [7:0] pc;
  logic [7:0] rf [4];

  logic [3:0] opc;
  logic [1:0] rd_sel, rs_sel;
  logic [7:0] rd_val, rs_val;

  assign opc    = imem_data[7:4];
  assign rd_sel = imem_data[3:2];
  assign rs_sel = imem_data[1:0];
  assign rd_val = rf[rd_sel];
  assign rs_val = rf[rs_sel];

  logic       ext_hi, a_from_ext, reg_we, wb_mem, mem_wr, is_bz;
  logic [1:0] dst;
  alu_op_t    alu_op;

  always_comb begin
    ext_hi     = 1'b0;
    a_from_ext = 1'b0;
    reg_we     = 1'b0;
    wb_mem     = 1'b0;
    mem_wr     = 1'b0;
    is_bz      = 1'b0;
    dst        = rd_sel;
    alu_op     = ALU_ZERO;
    unique case (opc)
      OP_LI:  begin a_from_ext = 1'b1; alu_op = ALU_A; dst = 2'd3; reg_we = 1'b1; end
      OP_LUI: begin a_from_ext = 1'b1; ext_hi = 1'b1; alu_op = ALU_A; dst = 2'd3; reg_we = 1'b1; end
      OP_LW:  begin wb_mem = 1'b1; reg_we = 1'b1; end
      OP_SW:  mem_wr = 1'b1;
      OP_ADD: begin alu_op = ALU_ADD; reg_we = 1'b1; end
      OP_MOV: begin alu_op = ALU_B; reg_we = 1'b1; end
      OP_BZ:  begin alu_op = ALU_B; is_bz = 1'b1; end
      default: ;
    endcase
  end

  logic [7:0] ext, alu_a, alu_s, wb_val, pc_next;
  logic       zf;

  assign ext   = ext_hi ? {imem_data[3:0], 4'h0} : {4'h0, imem_data[3:0]};
  assign alu_a = a_from_ext ? ext : rd_val;

  always_comb begin
    unique case (alu_op)
      ALU_ADD: alu_s = alu_a + rs_val;
      ALU_A:   alu_s = alu_a;
      ALU_B:   alu_s = rs_val;
      default: alu_s = 8'h00;
    endcase
  end

  assign zf      = (alu_s == 8'h00);
  assign wb_val  = wb_mem ? dmem_rdata : alu_s;
  assign pc_next = (is_bz && zf) ? pc + rd_val + 8'd1 : pc + 8'd1;

  assign imem_addr  = pc;
  assign dmem_addr  = rs_val;
  assign dmem_wdata = rd_val;
  assign dmem_we    = mem_wr && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 8'h00;
      for (int i = 0; i < 4; i++) rf[i] <= 8'h00;
    end else begin
      pc <= pc_next;
      if (reg_we) rf[dst] <= wb_val;
    end
  end
endmodule

// File: rtl/nib_core_sva.sv
module nib_core_sva (
  input logic       clk,
  input logic       rst,
  input logic [7:0] imem_addr,
  input logic [7:0] imem_data,
  input logic [7:0] dmem_addr,
  input logic [7:0] dmem_wdata,
  input logic       dmem_we,
  input logic [7:0] r3
);
  logic [3:0] op;
  assign op = imem_data[7:4];

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> imem_addr == 8'h00);
  p_reset_nowrite_r1: assert property (@(posedge clk) rst |-> !dmem_we);
  p_li_low_r2: assert property (@(posedge clk) disable iff (rst)
    op == 4'b1100 |=> r3 == {4'h0, $past(imem_data[3:0])});
  p_lui_high_r3: assert property (@(posedge clk) disable iff (rst)
    op == 4'b1101 |=> r3 == {$past(imem_data[3:0]), 4'h0});
  p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 4'b1001);
  p_bz_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (op == 4'b0111 && dmem_addr == 8'h00) |=> imem_addr == $past(imem_addr) + $past(dmem_wdata) + 8'd1);
  p_bz_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 4'b0111 && dmem_addr != 8'h00) |=> imem_addr == $past(imem_addr) + 8'd1);
  p_step_r11: assert property (@(posedge clk) disable iff (rst)
    op != 4'b0111 |=> imem_addr == $past(imem_addr) + 8'd1);
endmodule

bind nib_core nib_core_sva u_sva (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .r3(rf[3])
);

// File: tb/nib_core_test.sv
`timescale 1ns/1ps
module nib_core_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;

  logic [7:0] imem [256];
  logic [7:0] dmem [256];

  always #2.5 clk = ~clk;

  nib_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we)
  );

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] q_pc[$], q_addr[$], q_data[$];
  logic       q_we[$];
  string      q_tpc[$], q_twe[$], q_td[$];

  // reference model state
  logic [7:0] m_pc;
  logic [7:0] m_r [4];
  logic [7:0] m_mem [256];
  string      m_who [4];
  string      m_pctag;

  task automatic drive_cycle();
    logic [7:0] ins;
    logic [3:0] op;
    logic [1:0] rd, rs;
    ins = imem[m_pc];
    op = ins[7:4]; rd = ins[3:2]; rs = ins[1:0];
    q_pc.push_back(m_pc);
    q_tpc.push_back(m_pctag);
    q_we.push_back(op == 4'b1001);
    q_twe.push_back((op == 4'b1001) ? "R5" : "R10");
    q_addr.push_back(m_r[rs]);
    q_data.push_back(m_r[rd]);
    q_td.push_back(m_who[rd]);
    m_pctag = "R11";
    case (op)
      4'b1100: begin m_r[3] = {4'h0, ins[3:0]}; m_who[3] = "R2"; end
      4'b1101: begin m_r[3] = {ins[3:0], 4'h0}; m_who[3] = "R3"; end
      4'b1000: begin m_r[rd] = m_mem[m_r[rs]]; m_who[rd] = "R4"; end
      4'b1001: m_mem[m_r[rs]] = m_r[rd];
      4'b0010: begin m_r[rd] = m_r[rd] + m_r[rs]; m_who[rd] = "R6"; end
      4'b0011: begin m_r[rd] = m_r[rs]; m_who[rd] = "R7"; end
      4'b0111: m_pctag = (m_r[rs] == 8'h00) ? "R8" : "R9";
      default: m_pctag = "R10";
    endcase
    if (op == 4'b0111 && m_r[rs] == 8'h00) m_pc = m_pc + m_r[rd] + 8'd1;
    else m_pc = m_pc + 8'd1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #1;
      if (q_pc.size() > 0) begin
        logic [7:0] epc, ea, ed;
        logic ew;
        string tpc, twe, td;
        epc = q_pc.pop_front(); tpc = q_tpc.pop_front();
        ew = q_we.pop_front(); twe = q_twe.pop_front();
        ea = q_addr.pop_front(); ed = q_data.pop_front(); td = q_td.pop_front();
        check8(tpc, "pc", imem_addr, epc);
        check8(twe, "dmem_we", {7'b0, dmem_we}, {7'b0, ew});
        if (ew) begin
          check8("R5", "store addr", dmem_addr, ea);
          check8(td, "store data", dmem_wdata, ed);
        end
      end
    end
  end

  function automatic logic [7:0] rt(logic [3:0] op, logic [1:0] rd, logic [1:0] rs);
    return {op, rd, rs};
  endfunction
  function automatic logic [7:0] it(logic [3:0] op, logic [3:0] imm);
    return {op, imm};
  endfunction

  initial begin : stim
    int p;
    for (int i = 0; i < 256; i++) begin imem[i] = 8'h00; dmem[i] = 8'h00; end
    dmem[9] = 8'h3C;
    p = 0;
    imem[p++] = rt(4'b1001, 2'd1, 2'd0); // R1: reset regs visible
    imem[p++] = it(4'b1100, 4'h7);
    imem[p++] = it(4'b1101, 4'hC);      // R3
    imem[p++] = rt(4'b1001, 2'd3, 2'd0);
    imem[p++] = rt(4'b0011, 2'd2, 2'd3); // R7
    imem[p++] = rt(4'b1001, 2'd2, 2'd0);
    imem[p++] = it(4'b1100, 4'h5);      // R2
    imem[p++] = rt(4'b0010, 2'd2, 2'd3); // R6 -> C5
    imem[p++] = rt(4'b1001, 2'd2, 2'd3);
    imem[p++] = it(4'b1100, 4'h9);
    imem[p++] = rt(4'b1000, 2'd1, 2'd3); // R4 load 3C
    imem[p++] = rt(4'b1001, 2'd1, 2'd0);
    imem[p++] = 8'h00;                  // R10 no-ops
    imem[p++] = 8'hF5;
    imem[p++] = 8'hA6;
    imem[p++] = it(4'b1100, 4'h2);
    imem[p++] = rt(4'b0111, 2'd3, 2'd0); // R8 taken, skip two
    imem[p++] = rt(4'b1001, 2'd2, 2'd2);
    imem[p++] = rt(4'b1001, 2'd2, 2'd2);
    imem[p++] = rt(4'b0111, 2'd3, 2'd2); // R9 not taken
    imem[p++] = rt(4'b0111, 2'd0, 2'd0); // R8 zero offset
    imem[p++] = rt(4'b0010, 2'd0, 2'd2);
    imem[p++] = rt(4'b0010, 2'd0, 2'd2); // R6 wrap C5+C5=8A
    imem[p++] = rt(4'b1001, 2'd0, 2'd3);
    imem[p++] = rt(4'b1001, 2'd3, 2'd3);
    imem[p++] = it(4'b1101, 4'hF);
    imem[p++] = rt(4'b0011, 2'd1, 2'd3);
    imem[p++] = it(4'b1100, 4'hF);
    imem[p++] = rt(4'b0010, 2'd1, 2'd3); // FF
    imem[p++] = rt(4'b1001, 2'd1, 2'd2);
    imem[p++] = it(4'b1100, 4'h0);
    imem[p++] = rt(4'b0111, 2'd1, 2'd3); // R8 wrap: self loop

    m_pc = 8'h00;
    for (int i = 0; i < 4; i++) begin m_r[i] = 8'h00; m_who[i] = "R1"; end
    for (int i = 0; i < 256; i++) m_mem[i] = dmem[i];
    m_pctag = "R1";

    repeat (3) @(posedge clk);
    @(negedge clk);
    check8("R1", "pc in reset", imem_addr, 8'h00);
    check8("R1", "dmem_we in reset", {7'b0, dmem_we}, 8'h00);
    rst = 1'b0;
    for (int c = 0; c < 45; c++) begin
      drive_cycle();
      @(negedge clk);
    end
    #2;
    check8("R6", "mem[2]", dmem[2], m_mem[2]);
    check8("R5", "mem[C5]", dmem[8'hC5], 8'hFF);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #50000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule